// File: doc/BRIEF.md
# Single-Cycle FIR Multiply-Accumulate Engine

This datapath computes one FIR output for voiceband filtering: the inner product of a run of stored samples and a run of stored coefficients. The two operand stores are a 128-entry sample ring of 16-bit words and a 512-entry table of 13-bit coefficients. Each has its own read bus, so a sample and a coefficient reach the 16x16 signed multiplier in the same cycle. The product is registered and then added into a wide accumulator, which feeds its own value back into the adder. The engine therefore retires exactly one tap per clock.

A pass starts with a one-cycle start pulse that carries the tap count, the first sample address, the first coefficient address and the direction in which the sample address moves. Both address registers are counters. They are loaded once and then stepped every tap, wrapping around their store. When the last product has been summed, the engine raises a one-cycle done pulse and presents the rounded-down, saturated 16-bit result. Both stores have a simple write port so that samples and coefficients can be placed before a pass.

Top module: `fir_mac_engine`

## Requirements
- R1: After reset, busy_o and done_o are 0 and result_o is 0.
- R2: For a pass of N taps with first sample address s, first coefficient address c and direction d, the engine sums S[a_k] * C[(c+k) mod 512] for k = 0..N-1, where a_k = (s-k) mod 128 when d=0 and a_k = (s+k) mod 128 when d=1.
- R3: Each coefficient is a 13-bit two's complement value, sign-extended to 16 bits (bit 12 is the sign, so 0x1000 is -4096). Each sample is a 16-bit two's complement value, and the multiplier forms the full signed 32-bit product; -32768 times -4096 gives +2^27.
- R4: The sample address wraps from 127 to 0 when stepping up and from 0 to 127 when stepping down. The coefficient address wraps from 511 to 0.
- R5: For a start pulse with N > 0 that is sampled on clock edge E, busy_o is 1 for exactly N cycles after E. done_o is high for exactly one cycle, the cycle that follows edge E+N+1.
- R6: The sum is kept to 36 bits. result_o is the arithmetic right shift of the sum by 15, clamped to the range -32768..32767 (0x8000..0x7FFF).
- R7: Starting a pass clears the result to 0 in the cycle after the start edge. Once done has been given, result_o holds its value until the next start.
- R8: A pass with N = 0 gives result 0. Its done pulse comes in the cycle after edge E+1.
- R9: A start that arrives before the done pulse of the pass in progress aborts that pass. Only the new pass produces a done pulse and a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_we_i | input | 1 | Sample store write enable |
| smp_waddr_i | input | 7 | Sample store write address |
| smp_wdata_i | input | 16 | Sample store write data |
| coef_we_i | input | 1 | Coefficient store write enable |
| coef_waddr_i | input | 9 | Coefficient store write address |
| coef_wdata_i | input | 13 | Coefficient store write data |
| start_i | input | 1 | One-cycle pulse that launches a pass |
| taps_i | input | 8 | Number of taps in the pass, 0..255 |
| smp_base_i | input | 7 | Address of the first sample |
| coef_base_i | input | 9 | Address of the first coefficient |
| smp_up_i | input | 1 | Sample address direction: 1 steps up, 0 steps down |
| busy_o | output | 1 | High while taps are being fetched |
| done_o | output | 1 | One-cycle pulse when result_o is valid |
| result_o | output | 16 | Saturated filter output |

## Verification
Some protocol rules are checked on every cycle. done_o is never high for two cycles in a row. done_o never rises while taps are still being fetched. A nonzero start always raises busy_o on the next cycle. A zero-tap start that is not overridden gives done on the cycle after next. The result reads zero right after any start. The arithmetic cannot be checked that way. Only the bench scenarios show the correct inner product over both directions of address stepping and across both wrap points, the sign extension of a coefficient with bit 12 set, saturation at both rails, the exact done latency for each tap count, and that an aborted pass leaves no trace.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;
  localparam int SMP_W   = 16;
  localparam int COEF_W  = 13;
  localparam int SMP_DEPTH  = 128;
  localparam int COEF_DEPTH = 512;
  localparam int PROD_W  = 2 * SMP_W;
  localparam int GUARD_W = 4;
  localparam int ACC_W   = PROD_W + GUARD_W;
  localparam int FRAC_W  = SMP_W - 1;

  // window [FRAC_W+SMP_W-1:FRAC_W] with clamp when upper bits disagree
  function automatic logic [SMP_W-1:0] sat_out(input logic [ACC_W-1:0] a);
    if (a[ACC_W-1:FRAC_W+SMP_W-1] == {(ACC_W-FRAC_W-SMP_W+1){a[ACC_W-1]}})
      return a[FRAC_W+SMP_W-1:FRAC_W];
    else if (a[ACC_W-1])
      return {1'b1, {(SMP_W-1){1'b0}}};
    else
      return {1'b0, {(SMP_W-1){1'b1}}};
  endfunction
endpackage

// File: rtl/fir_mac_store.sv
module fir_mac_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read in the same cycle as the address so fetch and multiply share a step
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fir_mac_addr_ctr.sv
module fir_mac_addr_ctr #(
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  input  logic          up_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= base_i;
    else if (step_i) addr_q <= up_i ? addr_q + AW'(1) : addr_q - AW'(1);
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/fir_mac_datapath.sv
module fir_mac_datapath
  import fir_mac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              zero_i,
  input  logic              fetch_v_i,
  input  logic              fetch_last_i,
  input  logic [SMP_W-1:0]  smp_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic              done_o,
  output logic [SMP_W-1:0]  result_o
);
  logic signed [SMP_W-1:0]  coef_ext;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] prod_q;
  logic                     prod_v_q, prod_last_q;
  logic        [ACC_W-1:0]  acc_q;
  logic                     done_q;

  assign coef_ext = {{(SMP_W-COEF_W){coef_i[COEF_W-1]}}, coef_i};
  assign prod     = $signed(smp_i) * coef_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q      <= '0;
      prod_v_q    <= 1'b0;
      prod_last_q <= 1'b0;
      acc_q       <= '0;
      done_q      <= 1'b0;
    end else if (clr_i) begin
      // kill anything in flight; a zero-tap pass injects an empty last product
      prod_q      <= '0;
      prod_v_q    <= zero_i;
      prod_last_q <= zero_i;
      acc_q       <= '0;
      done_q      <= 1'b0;
    end else begin
      prod_q      <= prod;
      prod_v_q    <= fetch_v_i;
      prod_last_q <= fetch_last_i;
      if (prod_v_q) acc_q <= acc_q + {{GUARD_W{prod_q[PROD_W-1]}}, prod_q};
      done_q      <= prod_v_q & prod_last_q;
    end
  end

  assign done_o   = done_q;
  assign result_o = sat_out(acc_q);

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine
  import fir_mac_pkg::*;
#(
  parameter int SMP_AW  = $clog2(SMP_DEPTH),
  parameter int COEF_AW = $clog2(COEF_DEPTH),
  localparam int TAP_W  = SMP_AW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               smp_we_i,
  input  logic [SMP_AW-1:0]  smp_waddr_i,
  input  logic [SMP_W-1:0]   smp_wdata_i,
  input  logic               coef_we_i,
  input  logic [COEF_AW-1:0] coef_waddr_i,
  input  logic [COEF_W-1:0]  coef_wdata_i,
  input  logic               start_i,
  input  logic [TAP_W-1:0]   taps_i,
  input  logic [SMP_AW-1:0]  smp_base_i,
  input  logic [COEF_AW-1:0] coef_base_i,
  input  logic               smp_up_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [SMP_W-1:0]   result_o
);
  logic               busy_q, up_q;
  logic [TAP_W-1:0]   cnt_q;
  logic               zero_taps, last_tap, step;
  logic [SMP_AW-1:0]  smp_raddr;
  logic [COEF_AW-1:0] coef_raddr;
  logic [SMP_W-1:0]   smp_rd;
  logic [COEF_W-1:0]  coef_rd;

  assign zero_taps = (taps_i == '0);
  assign last_tap  = busy_q && (cnt_q == TAP_W'(1));
  assign step      = busy_q && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      up_q   <= 1'b0;
    end else if (start_i) begin
      busy_q <= !zero_taps;
      cnt_q  <= taps_i;
      up_q   <= smp_up_i;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - TAP_W'(1);
      if (last_tap) busy_q <= 1'b0;
    end
  end

  fir_mac_store #(.DW(SMP_W), .DEPTH(SMP_DEPTH)) u_smp_store (
    .clk_i, .we_i(smp_we_i), .waddr_i(smp_waddr_i), .wdata_i(smp_wdata_i),
    .raddr_i(smp_raddr), .rdata_o(smp_rd));

  fir_mac_store #(.DW(COEF_W), .DEPTH(COEF_DEPTH)) u_coef_store (
    .clk_i, .we_i(coef_we_i), .waddr_i(coef_waddr_i), .wdata_i(coef_wdata_i),
    .raddr_i(coef_raddr), .rdata_o(coef_rd));

  fir_mac_addr_ctr #(.AW(SMP_AW)) u_smp_ctr (
    .clk_i, .rst_ni, .load_i(start_i), .base_i(smp_base_i),
    .step_i(step), .up_i(up_q), .addr_o(smp_raddr));

  fir_mac_addr_ctr #(.AW(COEF_AW)) u_coef_ctr (
    .clk_i, .rst_ni, .load_i(start_i), .base_i(coef_base_i),
    .step_i(step), .up_i(1'b1), .addr_o(coef_raddr));

  fir_mac_datapath u_dp (
    .clk_i, .rst_ni, .clr_i(start_i), .zero_i(zero_taps),
    .fetch_v_i(busy_q), .fetch_last_i(last_tap),
    .smp_i(smp_rd), .coef_i(coef_rd),
    .done_o, .result_o);

  assign busy_o = busy_q;

  p_no_done_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);
  p_busy_on_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && taps_i != '0) |=> busy_o);
  p_zero_taps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && taps_i == '0) ##1 !start_i |=> done_o);
  p_clear_on_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (result_o == '0));
endmodule

// File: tb/fir_mac_engine_tb_top.sv
module fir_mac_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_we = 1'b0, coef_we = 1'b0, start = 1'b0, smp_up = 1'b0;
  logic [6:0]  smp_waddr = '0, smp_base = '0;
  logic [15:0] smp_wdata = '0;
  logic [8:0]  coef_waddr = '0, coef_base = '0;
  logic [12:0] coef_wdata = '0;
  logic [7:0]  taps = '0;
  logic        busy, done;
  logic [15:0] result;

  int smp_v  [128];
  int coef_v [512];
  int checks = 0, fails = 0;
  int unsigned cyc = 0;
  logic [15:0] exp_res_q [$];
  int unsigned exp_cyc_q [$];
  string       exp_req_q [$];
  logic [15:0] last_exp = '0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fir_mac_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .smp_we_i(smp_we), .smp_waddr_i(smp_waddr), .smp_wdata_i(smp_wdata),
    .coef_we_i(coef_we), .coef_waddr_i(coef_waddr), .coef_wdata_i(coef_wdata),
    .start_i(start), .taps_i(taps), .smp_base_i(smp_base), .coef_base_i(coef_base),
    .smp_up_i(smp_up), .busy_o(busy), .done_o(done), .result_o(result));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_smp(input int a, input int v);
    @(negedge clk);
    smp_we = 1'b1; smp_waddr = 7'(a); smp_wdata = 16'(v);
    smp_v[a] = int'($signed(16'(v)));
    @(negedge clk);
    smp_we = 1'b0;
  endtask

  task automatic wr_coef(input int a, input int v);
    @(negedge clk);
    coef_we = 1'b1; coef_waddr = 9'(a); coef_wdata = 13'(v);
    coef_v[a] = int'($signed(13'(v)));
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  // R2 R3 R4 R6: reference inner product with wrap, sign extension, floor and clamp
  function automatic logic [15:0] ref_fir(input int n, input int sb, input int cb, input bit up);
    longint s = 0;
    longint q;
    for (int k = 0; k < n; k++) begin
      int si = (sb + (up ? k : -k)) & 127;
      int ci = (cb + k) & 511;
      s += longint'(smp_v[si]) * longint'(coef_v[ci]);
    end
    q = s >>> 15;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return 16'(q);
  endfunction

  task automatic launch(input int n, input int sb, input int cb, input bit up);
    start = 1'b1; taps = 8'(n); smp_base = 7'(sb); coef_base = 9'(cb); smp_up = up;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_pass(input int n, input int sb, input int cb, input bit up, input string req);
    logic [15:0] e;
    int b;
    e = ref_fir(n, sb, cb, up);
    @(negedge clk);
    exp_res_q.push_back(e);
    exp_cyc_q.push_back(cyc + n + 2);
    exp_req_q.push_back(req);
    last_exp = e;
    launch(n, sb, cb, up);
    check(result == 16'h0, "R7 cleared after start", result, 0);
    b = 0;
    while (busy) begin b++; @(negedge clk); end
    check(b == n, "R5 busy length", b, n);
    while (exp_res_q.size() != 0) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_res_q.size() == 0) begin
        check(1'b0, "R9 unexpected done", result, 0);
      end else begin
        logic [15:0] e;
        int unsigned ec;
        string r;
        e  = exp_res_q.pop_front();
        ec = exp_cyc_q.pop_front();
        r  = exp_req_q.pop_front();
        check(result == e, r, result, e);
        check(cyc == ec, "R5 done latency", cyc, ec);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 reset flags", {busy, done}, 0);
    check(result == 16'h0, "R1 reset result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && result == 16'h0, "R1 after release", result, 0);

    for (int i = 0; i < 128; i++) wr_smp(i, int'($urandom));
    for (int i = 0; i < 512; i++) wr_coef(i, int'($urandom));

    run_pass(16, 40, 0, 1'b0, "R2 random down");
    run_pass(37, 120, 500, 1'b1, "R4 up wrap both stores");
    run_pass(10, 3, 200, 1'b0, "R4 down wrap");
    run_pass(1, 77, 9, 1'b1, "R2 single tap");

    // R3 extreme: -32768 * -4096 = 2^27 -> 4096
    wr_smp(50, 16'h8000);
    wr_coef(300, 13'h1000);
    run_pass(1, 50, 300, 1'b0, "R3 extreme product");
    wr_smp(51, 1);
    run_pass(1, 51, 300, 1'b1, "R3 coef sign extension");

    // R6 saturation at both rails
    for (int i = 64; i < 80; i++) wr_smp(i, 16'h8000);
    for (int i = 100; i < 116; i++) wr_coef(i, 13'h1000);
    run_pass(16, 64, 100, 1'b1, "R6 positive saturation");
    check(last_exp == 16'h7fff, "R6 positive rail ref", last_exp, 16'h7fff);
    for (int i = 100; i < 116; i++) wr_coef(i, 13'h0fff);
    run_pass(16, 79, 100, 1'b0, "R6 negative saturation");
    check(last_exp == 16'h8000, "R6 negative rail ref", last_exp, 16'h8000);

    run_pass(0, 10, 10, 1'b0, "R8 zero taps");

    // R9 abort a pass in flight
    @(negedge clk);
    launch(20, 30, 60, 1'b1);
    repeat (5) @(negedge clk);
    run_pass(12, 90, 400, 1'b0, "R9 restart result");

    run_pass(255, 0, 256, 1'b1, "R2 longest pass");
    for (int j = 0; j < 6; j++)
      run_pass(int'($urandom_range(1, 60)), int'($urandom_range(0, 127)),
               int'($urandom_range(0, 511)), 1'($urandom), "R2 random pass");

    repeat (5) @(negedge clk);
    check(result == last_exp, "R7 result held", result, last_exp);
    check(done == 1'b0, "R5 no stray done", done, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule